// File: doc/BRIEF.md
# Parallel Decision-Directed Carrier Phase Tracker

This block recovers the carrier phase of a square 64-QAM stream. Before it, a serial symbol stream is split across P lanes, so P symbols arrive together on each valid clock. Lane 0 carries the newest symbol of the round, and each higher lane carries the next older one. Every symbol in the round is rotated back by one phase value that all lanes share. Each derotated symbol is then sliced on I and on Q separately, to one of eight levels per axis. The levels are ±1, ±3, ±5 and ±7 times a programmable step.

The round's decisions feed a single error phasor. For each lane, the derotated symbol is multiplied by the conjugate of its decided level. The P products are summed, so each lane's phase error counts in proportion to the energy of its constellation point. An iterative vectoring rotation turns this sum into an angle. The angle is added to the phase the round was derotated with, and the result becomes the new shared estimate.

The feedback path holds exactly D register stages, so a round is corrected by the estimate formed D rounds earlier. That is a lag of D·P symbols. The starting phase is loaded from outside. A load also discards every estimate still in flight. The phase is a 16-bit unsigned fraction of a full turn and wraps modulo one turn.

Top module: `dd_phase_tracker`

## Requirements
- R1: Every lane of a round is derotated by the same phase value, whatever its position in the round. Lane l occupies bits [l*W +: W] of each bus, and lane 0 is the newest symbol.
- R2: Each output pair equals the input pair rotated by minus the applied phase φ, where φ/65536 is a fraction of a full turn. The error is at most a few LSBs, and results saturate to the W-bit signed range.
- R3: Each axis decision is an index n in 0..7, equal to the number of thresholds {-6s, -4s, -2s, 0, 2s, 4s, 6s} that the derotated value is greater than or equal to (s = step). Index n stands for level 2n-7, so values beyond ±6s saturate to index 7 or 0.
- R4: Outputs are registered one clock after a valid input, and out_valid is high exactly in the clock after in_valid.
- R5: Each tracked round updates the estimate to its applied phase plus the angle of the sum of derotated symbol times conjugate decided level. After the loop latency, a constant phase rotation of the input is therefore removed.
- R6: The estimate from round n first takes effect on round n+D. Rounds 0..D-1 after a reset or a load use the starting phase.
- R7: While in_valid is low, the outputs, the pipeline and the phase hold, and idle clocks do not count toward the D-round lag.
- R8: load writes load_phase into the estimate. It wins over an update in the same clock, and it discards all updates still in flight. A round presented in the load clock is still derotated with the old phase.
- R9: The phase accumulator wraps modulo 2^16, so an update across zero yields a correct small positive phase.
- R10: A synchronous reset clears all outputs, out_valid and the phase to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A round of P symbols is present |
| in_i | input | P*W | Received in-phase values, signed, one per lane |
| in_q | input | P*W | Received quadrature values, signed, one per lane |
| step | input | W | Constellation level spacing (unsigned, positive) |
| load | input | 1 | Load the starting phase |
| load_phase | input | 16 | Starting phase, fraction of a full turn |
| out_valid | output | 1 | Output round is new |
| out_i | output | P*W | Derotated in-phase values |
| out_q | output | P*W | Derotated quadrature values |
| dec_i | output | 3*P | In-phase decision index per lane |
| dec_q | output | 3*P | Quadrature decision index per lane |

## Verification
The hardest case to bring about is a load that lands while estimates are still in the loop. For it to show, the tracker must first lock onto a rotated stream, so that every pipeline slot carries an update that would overwrite the loaded phase. The stimulus tracks a 10-degree rotation until it settles, then presents a round together with a load. It then checks that the next D rounds use exactly the loaded phase and not a stale estimate. Idle gaps placed inside the lag window show that the latency counts rounds, not clocks.

// File: rtl/dd_phase_tracker.sv
module dd_phase_tracker #(
  parameter int P = 8,
  parameter int W = 12,
  parameter int D = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [P*W-1:0] in_i,
  input  logic [P*W-1:0] in_q,
  input  logic [W-1:0]   step,
  input  logic           load,
  input  logic [15:0]    load_phase,
  output logic           out_valid,
  output logic [P*W-1:0] out_i,
  output logic [P*W-1:0] out_q,
  output logic [3*P-1:0] dec_i,
  output logic [3*P-1:0] dec_q
);
  localparam int PW  = 16;
  localparam int G   = 3;
  localparam int IW  = W + G + 2;
  localparam int VW  = W + 5 + $clog2(P);
  localparam int CW  = VW + 2;
  localparam int NIT = 12;
  localparam logic [PW-1:0] EIGHTH = 16'h2000;
  localparam logic signed [12:0] GAIN = 13'sd2487;
  localparam logic signed [IW+12:0] PMAX = (IW+13)'((1 << (W-1)) - 1);
  localparam logic signed [IW+12:0] PMIN = -PMAX - (IW+13)'(1);

  function automatic logic [PW-1:0] atan_lut(input int i);
    case (i)
      0: return 16'd8192;  1: return 16'd4836;  2: return 16'd2555;
      3: return 16'd1297;  4: return 16'd651;   5: return 16'd326;
      6: return 16'd163;   7: return 16'd81;    8: return 16'd41;
      9: return 16'd20;    10: return 16'd10;   default: return 16'd5;
    endcase
  endfunction

  function automatic logic [W-1:0] scale_sat(input logic signed [IW-1:0] v);
    logic signed [IW+12:0] p;
    p = v * GAIN;
    p = p >>> (12 + G);
    if (p > PMAX) return PMAX[W-1:0];
    if (p < PMIN) return PMIN[W-1:0];
    return p[W-1:0];
  endfunction

  function automatic logic [2*W-1:0] derot(input logic signed [W-1:0] xi,
                                           input logic signed [W-1:0] xq,
                                           input logic [PW-1:0] th);
    logic [PW-1:0] sh;
    logic [1:0] q;
    logic signed [PW-1:0] z;
    logic signed [IW-1:0] x0, y0, x, y, t;
    sh = th + EIGHTH;
    q  = sh[PW-1:PW-2];
    z  = signed'(th - {q, {(PW-2){1'b0}}});
    x0 = IW'(xi) <<< G;
    y0 = IW'(xq) <<< G;
    case (q)
      2'd0: begin x = x0;  y = y0;  end
      2'd1: begin x = -y0; y = x0;  end
      2'd2: begin x = -x0; y = -y0; end
      default: begin x = y0; y = -x0; end
    endcase
    for (int i = 0; i < NIT; i++) begin
      t = x;
      if (!z[PW-1]) begin
        x = x - (y >>> i); y = y + (t >>> i); z = z - signed'(atan_lut(i));
      end else begin
        x = x + (y >>> i); y = y - (t >>> i); z = z + signed'(atan_lut(i));
      end
    end
    return {scale_sat(x), scale_sat(y)};
  endfunction

  function automatic logic [PW-1:0] vec_angle(input logic signed [VW-1:0] vi,
                                              input logic signed [VW-1:0] vq);
    logic signed [CW-1:0] x, y, t;
    logic [PW-1:0] z;
    if (vi == '0 && vq == '0) return '0;
    x = CW'(vi);
    y = CW'(vq);
    z = '0;
    if (x[CW-1]) begin x = -x; y = -y; z = 16'h8000; end
    for (int i = 0; i < NIT; i++) begin
      t = x;
      if (!y[CW-1]) begin
        x = x + (y >>> i); y = y - (t >>> i); z = z + atan_lut(i);
      end else begin
        x = x - (y >>> i); y = y + (t >>> i); z = z - atan_lut(i);
      end
    end
    return z;
  endfunction

  function automatic logic [2:0] slice(input logic signed [W-1:0] v, input logic [W-1:0] s);
    logic signed [W+3:0] vv, s2, thr;
    logic [2:0] n;
    vv  = (W+4)'(v);
    s2  = signed'({3'b000, s, 1'b0});
    thr = -(s2 + s2 + s2);
    n   = '0;
    for (int k = 0; k < 7; k++) begin
      if (vv >= thr) n = n + 3'd1;
      thr = thr + s2;
    end
    return n;
  endfunction

  logic [PW-1:0] phase, app1, app2, neg_ph;
  logic [PW-1:0] upd [D-3];
  logic [D-2:0]  tg;
  logic signed [VW-1:0] vr_i, vr_q, vs_i, vs_q;
  logic [P*W-1:0] nx_i, nx_q;
  logic [3*P-1:0] nx_di, nx_dq;

  assign neg_ph = -phase;

  for (genvar l = 0; l < P; l++) begin : g_lane
    logic [2*W-1:0] rr;
    assign rr = derot($signed(in_i[l*W +: W]), $signed(in_q[l*W +: W]), neg_ph);
    assign nx_i[l*W +: W]  = rr[2*W-1:W];
    assign nx_q[l*W +: W]  = rr[W-1:0];
    assign nx_di[3*l +: 3] = slice(rr[2*W-1:W], step);
    assign nx_dq[3*l +: 3] = slice(rr[W-1:0], step);
  end

  always_comb begin
    logic signed [VW-1:0] li, lq, oi, oq;
    vs_i = '0;
    vs_q = '0;
    for (int l = 0; l < P; l++) begin
      li = VW'(signed'({2'b00, dec_i[3*l +: 3], 1'b0})) - VW'(7);
      lq = VW'(signed'({2'b00, dec_q[3*l +: 3], 1'b0})) - VW'(7);
      oi = VW'($signed(out_i[l*W +: W]));
      oq = VW'($signed(out_q[l*W +: W]));
      vs_i = vs_i + li * oi + lq * oq;
      vs_q = vs_q + li * oq - lq * oi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i <= '0; out_q <= '0; dec_i <= '0; dec_q <= '0;
      phase <= '0; app1 <= '0; app2 <= '0;
      vr_i <= '0; vr_q <= '0; tg <= '0;
      for (int j = 0; j < D-3; j++) upd[j] <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= nx_i; out_q <= nx_q; dec_i <= nx_di; dec_q <= nx_dq;
        app1 <= phase;
        vr_i <= vs_i; vr_q <= vs_q; app2 <= app1;
        upd[0] <= app2 + vec_angle(vr_i, vr_q);
        for (int j = 1; j < D-3; j++) upd[j] <= upd[j-1];
        tg <= {tg[D-3:0], 1'b1};
      end
      if (load) begin
        phase <= load_phase;
        tg <= '0;
      end else if (in_valid && tg[D-2]) begin
        phase <= upd[D-4];
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R4
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_i) && $stable(out_q) && $stable(dec_i) && $stable(dec_q))); // R7
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !load) |=> $stable(phase)); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> (phase == $past(load_phase))); // R8
endmodule

// File: tb/dd_phase_tracker_test.sv
`timescale 1ns/1ps
module dd_phase_tracker_test;
  localparam int P = 8;
  localparam int W = 12;
  localparam int D = 4;
  localparam int STEP = 200;
  localparam int TOL = 6;
  localparam real TWO_PI = 6.283185307179586;
  localparam int TI [16] = '{7,-7,5,-5,3,-3,1,-1,7,1,-3,5,-7,3,-1,-5};
  localparam int TQ [16] = '{7,-7,-5,5,1,-1,3,-3,-1,-7,5,3,-3,-5,7,1};
  localparam int KI [8]  = '{1,-3,5,-1,3,-5,1,-3};
  localparam int KQ [8]  = '{1,3,5,-1,-3,-5,-3,1};

  logic clk = 1'b0;
  logic rst, in_valid, load, out_valid;
  logic [P*W-1:0] in_i, in_q, out_i, out_q;
  logic [W-1:0] step;
  logic [15:0] load_phase;
  logic [3*P-1:0] dec_i, dec_q;

  int checks = 0, errors = 0;
  bit done = 0;
  int cur_i [P], cur_q [P];

  always #2 clk = ~clk;

  dd_phase_tracker #(.P(P), .W(W), .D(D)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .step(step), .load(load), .load_phase(load_phase), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q), .dec_i(dec_i), .dec_q(dec_q));

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int clampw(int v);
    return (v > 2047) ? 2047 : ((v < -2048) ? -2048 : v);
  endfunction

  function automatic int exp_slice(int v);
    int n = 0;
    for (int k = 0; k < 7; k++) if (v >= (2*k - 6) * STEP) n++;
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input int got, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  task automatic fill(input int set, input int base, input int th);
    real a = th * TWO_PI / 65536.0;
    for (int l = 0; l < P; l++) begin
      int li = (set == 0) ? TI[(base + l) % 16] : KI[l];
      int lq = (set == 0) ? TQ[(base + l) % 16] : KQ[l];
      cur_i[l] = clampw(rnd(STEP * (li * $cos(a) - lq * $sin(a))));
      cur_q[l] = clampw(rnd(STEP * (li * $sin(a) + lq * $cos(a))));
    end
  endtask

  task automatic drive(input bit ld, input int ldph);
    for (int l = 0; l < P; l++) begin
      in_i[l*W +: W] = W'(cur_i[l]);
      in_q[l*W +: W] = W'(cur_q[l]);
    end
    in_valid = 1'b1; load = ld; load_phase = 16'(ldph);
    @(negedge clk);
    in_valid = 1'b0; load = 1'b0;
  endtask

  task automatic idle_load(input int ldph);
    load = 1'b1; load_phase = 16'(ldph);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic check_out(input int ph, input bit cd, input string tag);
    real a = ph * TWO_PI / 65536.0;
    chk(out_valid == 1'b1, {tag, " out_valid"}, int'(out_valid), 1);
    for (int l = 0; l < P; l++) begin
      int ei = clampw(rnd(cur_i[l] * $cos(a) + cur_q[l] * $sin(a)));
      int eq = clampw(rnd(cur_q[l] * $cos(a) - cur_i[l] * $sin(a)));
      int gi = $signed(out_i[l*W +: W]);
      int gq = $signed(out_q[l*W +: W]);
      chk((gi - ei <= TOL) && (ei - gi <= TOL), {tag, " I"}, gi, ei);
      chk((gq - eq <= TOL) && (eq - gq <= TOL), {tag, " Q"}, gq, eq);
      if (cd) begin
        chk(int'(dec_i[3*l +: 3]) == exp_slice(ei), {tag, " dec I"}, int'(dec_i[3*l +: 3]), exp_slice(ei));
        chk(int'(dec_q[3*l +: 3]) == exp_slice(eq), {tag, " dec Q"}, int'(dec_q[3*l +: 3]), exp_slice(eq));
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [P*W-1:0] hold_i;
    logic [3*P-1:0] hold_d;
    rst = 1'b1; in_valid = 1'b0; load = 1'b0; load_phase = '0;
    in_i = '0; in_q = '0; step = W'(STEP);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
    chk(out_i == '0 && out_q == '0, "R10 data", int'(out_i[W-1:0]), 0);
    chk(dec_i == '0 && dec_q == '0, "R10 decisions", int'(dec_i[2:0]), 0);
    rst = 1'b0;

    // R1 R2 R3: vector table at zero phase
    for (int r = 0; r < 6; r++) begin
      fill(0, r * 3, 0); drive(1'b0, 0);
      check_out(0, 1'b1, "R1 R2 R3 table phase 0");
    end

    // R8 R2: loaded phase of 22.5 degrees applied exactly
    idle_load(16'h1000);
    for (int r = 0; r < 6; r++) begin
      fill(0, r * 5 + 1, 16'h1000); drive(1'b0, 0);
      check_out(16'h1000, 1'b1, "R8 R2 loaded phase");
    end

    // R3 slicer boundaries and saturation at phase 0
    idle_load(0);
    cur_i = '{2047, -2048, 405, 395, -395, -405, 1205, 1195};
    cur_q = '{-1195, 1195, -1205, 0, 805, 795, -795, -805};
    drive(1'b0, 0);
    check_out(0, 1'b1, "R3 slicer thresholds");

    // R5 R6 R7: track a 10 degree rotation with idle gaps inside the lag window
    idle_load(0);
    for (int r = 0; r < 3; r++) begin
      fill(1, 0, 16'h071C); drive(1'b0, 0);
      check_out(0, 1'b1, "R6 before lag");
    end
    hold_i = out_i; hold_d = dec_i;
    for (int g = 0; g < 3; g++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 idle out_valid", int'(out_valid), 0);
      chk(out_i == hold_i && dec_i == hold_d, "R7 idle hold", int'(out_i[W-1:0]), int'(hold_i[W-1:0]));
    end
    fill(1, 0, 16'h071C); drive(1'b0, 0);
    check_out(0, 1'b1, "R6 R7 last round before update");
    for (int r = 0; r < 4; r++) begin
      fill(1, 0, 16'h071C); drive(1'b0, 0);
      check_out(16'h071C, 1'b1, "R5 R6 tracked");
    end

    // R8: load together with a valid round while updates are in flight
    fill(1, 0, 16'h071C); drive(1'b1, 16'h4000);
    check_out(16'h071C, 1'b1, "R8 load-cycle round uses old phase");
    for (int r = 0; r < D; r++) begin
      fill(1, 0, 16'h071C); drive(1'b0, 0);
      check_out(16'h4000, 1'b0, "R8 stale updates discarded");
    end

    // R9: wrap across zero
    idle_load(16'hFF00);
    for (int r = 0; r < D; r++) begin
      fill(1, 0, 16'h038E); drive(1'b0, 0);
      check_out(16'hFF00, 1'b1, "R9 start below zero");
    end
    for (int r = 0; r < 2; r++) begin
      fill(1, 0, 16'h038E); drive(1'b0, 0);
      check_out(16'h038E, 1'b1, "R9 wrapped estimate");
    end

    finish_run();
  end
endmodule